// File: doc/BRIEF.md
# Registered Output Macrocell with Test Load

This block is a single registered output cell of a small programmable logic device. A one-bit register captures the sum-of-products term on each rising clock edge. A polarity stage between the register and the output pin lets the same stored state drive the pin either as-is or inverted. The clear, the set and the power-on initialisation all act on the stored bit and never on the pin. The level seen on the pin after any of them therefore depends on the polarity selection.

For production test, a load strobe copies the value present on the pin straight into the register. This lets a test program place a state machine in any state, including states that normal operation never reaches, and then watch how it recovers. A protection flag blocks this load path entirely. While the flag is set, the strobe is ignored and the register keeps its normal behaviour.

The clear is asynchronous. The set and the load are synchronous. When several controls are active in the same cycle, the priority is clear, then load, then set, then the data input. An active-low power-on reset forces the register low in the same way that the clear does.

Top module: `pld_macrocell`

## Requirements
- R1: While `clr` is high, `q_state` is 0 without waiting for a clock edge.
- R2: At a rising edge with `preset` high, `clr` low and no enabled load, `q_state` becomes 1.
- R3: `pin_out` equals `q_state` when `inv_sel` is 0 and equals the complement of `q_state` when `inv_sel` is 1. This holds in every cycle, including just after a clear, set or power-on reset.
- R4: While `por_n` is low, `q_state` is 0, so `pin_out` reads 0 with `inv_sel` at 0 and reads 1 with `inv_sel` at 1.
- R5: At a rising edge with `preload_en` high and `secure` low, `q_state` takes the value of `pin_in`. This overrides both `preset` and `d_in`.
- R6: While `secure` is high, `preload_en` has no effect, and the next state comes from `preset` or `d_in`.
- R7: At a rising edge with no clear, no enabled load and no set, `q_state` takes `d_in`.
- R8: `clr` overrides both `preset` and an enabled load. With all three active, `q_state` is 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| clr | input | 1 | Register clear, active high, asynchronous |
| preset | input | 1 | Register set, active high, synchronous |
| d_in | input | 1 | Sum-of-products term feeding the register |
| inv_sel | input | 1 | Output polarity: 0 true, 1 inverted |
| preload_en | input | 1 | Test load strobe, active high, synchronous |
| pin_in | input | 1 | Value sensed on the output pin, used by the load |
| secure | input | 1 | Protection flag; high blocks the load path |
| pin_out | output | 1 | Pin drive after the polarity stage |
| q_state | output | 1 | Raw register state |

## Verification
The clocked properties assume that every input changes away from the rising clock edge. They also assume that `clr` and `por_n` are not released exactly at an edge. The next-state checks are switched off for any cycle in which either reset is active, so the properties check only the synchronous priority chain. The bench applies every input change at the falling edge. The asynchronous clear is the one exception: it is raised a short time after a falling edge, and its effect is observed before the following rising edge. Random traffic keeps clears infrequent so that long runs of set, load and data cycles occur between them.

// File: rtl/pld_macrocell.sv
module pld_macrocell (
  input  logic clk,
  input  logic por_n,
  input  logic clr,
  input  logic preset,
  input  logic d_in,
  input  logic inv_sel,
  input  logic preload_en,
  input  logic pin_in,
  input  logic secure,
  output logic pin_out,
  output logic q_state
);

  logic q;
  logic load_ok;

  assign load_ok = preload_en & ~secure;

  always_ff @(posedge clk or negedge por_n or posedge clr) begin
    if (!por_n || clr) q <= 1'b0;
    else if (load_ok)  q <= pin_in;
    else if (preset)   q <= 1'b1;
    else               q <= d_in;
  end

  assign q_state = q;
  assign pin_out = inv_sel ? ~q : q;

  always_ff @(posedge clk) begin
    if (clr) p_clear_low_r1: assert (q_state == 1'b0) else $error("clear did not hold register low");
    if (!por_n) p_por_low_r4: assert (q_state == 1'b0) else $error("power-on reset did not hold register low");
  end

  p_set_r2: assert property (@(posedge clk) disable iff (!por_n || clr)
    (preset && !(preload_en && !secure)) |=> q_state);

  p_load_r5: assert property (@(posedge clk) disable iff (!por_n || clr)
    (preload_en && !secure) |=> (q_state == $past(pin_in)));

  p_locked_r6: assert property (@(posedge clk) disable iff (!por_n || clr)
    (preload_en && secure && !preset) |=> (q_state == $past(d_in)));

  p_data_r7: assert property (@(posedge clk) disable iff (!por_n || clr)
    (!preload_en && !preset) |=> (q_state == $past(d_in)));

endmodule

// File: tb/pld_macrocell_tb.sv
module pld_macrocell_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic por_n, clr, preset, d_in, inv_sel, preload_en, pin_in, secure;
  logic pin_out, q_state;
  int checks = 0;
  int fails = 0;
  logic exp_q;

  pld_macrocell u_dut (
    .clk(clk), .por_n(por_n), .clr(clr), .preset(preset), .d_in(d_in),
    .inv_sel(inv_sel), .preload_en(preload_en), .pin_in(pin_in),
    .secure(secure), .pin_out(pin_out), .q_state(q_state)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic model(input logic q);
    if (!por_n || clr) return 1'b0;
    if (preload_en && !secure) return pin_in;
    if (preset) return 1'b1;
    return d_in;
  endfunction

  function automatic string tag_of();
    if (clr && (preset || preload_en)) return "R8";
    if (clr) return "R1";
    if (preload_en && !secure) return "R5";
    if (preload_en) return "R6";
    if (preset) return "R2";
    return "R7";
  endfunction

  task automatic step();
    string t;
    t = tag_of();
    exp_q = model(exp_q);
    @(posedge clk);
    #1;
    chk(t, q_state, exp_q);
    chk("R3", pin_out, exp_q ^ inv_sel);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    por_n = 0; clr = 0; preset = 1; d_in = 1; inv_sel = 0;
    preload_en = 0; pin_in = 1; secure = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R4", q_state, 1'b0);
    chk("R4", pin_out, 1'b0);
    inv_sel = 1;
    #1;
    chk("R4", pin_out, 1'b1);
    por_n = 1; preset = 0; d_in = 0; exp_q = 0;
    @(negedge clk);

    preset = 1;                           step();  // R2
    preset = 0; d_in = 0;                 step();  // R7
    inv_sel = 0; preload_en = 1; pin_in = 1; step(); // R5
    preset = 1; pin_in = 0;               step();  // R5 over preset
    preset = 0; secure = 1; pin_in = 1; d_in = 0; step(); // R6
    d_in = 1;                             step();  // R6
    secure = 0; preset = 1; clr = 1;      step();  // R8
    clr = 0; preload_en = 0; preset = 1;  step();
    preset = 0; d_in = 1;
    #2 clr = 1;
    #1 chk("R1", q_state, 1'b0);
    chk("R3", pin_out, 1'b0);
    exp_q = 0;
    @(negedge clk);
    clr = 0; inv_sel = 1;                 step();

    for (int i = 0; i < 3000; i++) begin
      clr        = ($urandom_range(0, 15) == 0);
      preset     = ($urandom_range(0, 7) == 0);
      preload_en = ($urandom_range(0, 5) == 0);
      secure     = $urandom_range(0, 1);
      d_in       = $urandom_range(0, 1);
      pin_in     = $urandom_range(0, 1);
      inv_sel    = $urandom_range(0, 1);
      step();
    end
    finish_run();
  end
endmodule